// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a standard-mode two-wire bus slave that keeps six 8-bit configuration registers. It answers a fixed pair of address bytes: one for writes and one for reads. There is no register offset on the bus. A write transfer carries two leading bytes, a command and a count, that the slave acknowledges and then throws away. The data bytes that follow fill the registers from register 0 upward. A read transfer returns a count byte and then the registers in ascending order.

The bus lines are sampled by the system clock through two-flop synchronizers, so the system clock must run well above the bus rate. The slave drives SDA only as an open-drain enable. All six registers are shown at once on a parallel output for the logic they configure. A new value appears on that output as soon as the slave acknowledges the byte that carries it.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, the parallel output holds 0x1E in register 0, 0xFF in registers 1 and 2, 0x00 in registers 3 and 4, and 0x06 in register 5. Register k sits at bits 8k+7..8k. SDA is released (sda_oe = 0).
- R2: The address byte 0xD2 (write) and the address byte 0xD3 (read) are acknowledged: sda_oe pulls SDA low through the ninth clock. Any other address byte gets no acknowledge, and the rest of that transfer changes no register.
- R3: In a write, the first two bytes after the address (command, count) are each acknowledged and change no register.
- R4: Write data bytes load registers 0, 1, 2 and so on in ascending order, and each one is acknowledged. The new value is on the parallel output by the end of that byte's acknowledge clock, before any stop.
- R5: A stop after any complete byte ends the write. Registers already written keep their new values and all others keep their previous values.
- R6: Write data bytes after register 5 are acknowledged and discarded.
- R7: A read sends the count byte 0x06 first, then registers 0 to 5, MSB first. Any byte requested after register 5 reads as 0xFF.
- R8: A not-acknowledge from the master during a read ends the transmission. SDA then stays released whatever SCL does, until the next start.
- R9: A start is SDA falling while SCL is high and a stop is SDA rising while SCL is high. Bytes are MSB first. Every transfer begins again at register 0.
- R10: A read transfer leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | 48 | All six registers, register k at bits 8k+7..8k |

## Verification
A wrong byte index shows at the ports within one byte. Either the wrong slice of regs_o changes at that byte's acknowledge, or the read-back stream comes out shifted against the written pattern. A bit counter or state that is out of step shows up as a missing or misplaced acknowledge on the ninth clock of the byte where it goes wrong. After a not-acknowledge, a slave that has not returned to idle is seen as SDA pulled low during the idle clocks that follow, before the next start.

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int              NREG      = 6,
  parameter logic [6:0]      DEV_ADDR  = 7'h69,
  parameter logic [NREG*8-1:0] RESET_VAL = 48'h06_00_00_FF_FF_1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);

  localparam int IW = $clog2(NREG + 3) + 1;
  localparam logic [IW-1:0] IDX_MAX = IW'(NREG + 2);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_RX, ST_ACK, ST_TX, ST_MACK} st_t;

  st_t               st;
  logic [1:0]        scl_sy, sda_sy;
  logic              scl_q, sda_q;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg, txsh, tx_byte;
  logic [IW-1:0]     idx;
  logic              rd, got;
  logic [NREG*8-1:0] regs;

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  assign regs_o = regs;

  always_comb begin
    tx_byte = 8'hFF;
    if (idx == '0) tx_byte = 8'(NREG);
    for (int k = 0; k < NREG; k++)
      if (idx == IW'(k + 1)) tx_byte = regs[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      st     <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txsh   <= '0;
      idx    <= '0;
      rd     <= 1'b0;
      got    <= 1'b0;
      sda_oe <= 1'b0;
      regs   <= RESET_VAL;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      if (start_det) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        idx    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (st == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  rd     <= shreg[0];
                  st     <= ST_ACK;
                  sda_oe <= 1'b1;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                st     <= ST_ACK;
                sda_oe <= 1'b1;
                for (int k = 0; k < NREG; k++)
                  if (idx == IW'(k + 2)) regs[8*k +: 8] <= shreg;
                if (idx != IDX_MAX) idx <= idx + 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (rd) begin
                st     <= ST_TX;
                txsh   <= tx_byte;
                sda_oe <= ~tx_byte[7];
                if (idx != IDX_MAX) idx <= idx + 1'b1;
              end else begin
                st     <= ST_RX;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                bitcnt <= '0;
                sda_oe <= 1'b0;
                got    <= 1'b0;
                st     <= ST_MACK;
              end else begin
                txsh   <= {txsh[6:0], 1'b1};
                sda_oe <= ~txsh[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              if (sda_s) st <= ST_IDLE;
              else       got <= 1'b1;
            end else if (scl_fall && got) begin
              st     <= ST_TX;
              txsh   <= tx_byte;
              sda_oe <= ~tx_byte[7];
              if (idx != IDX_MAX) idx <= idx + 1'b1;
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe); // R8
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR && !sda_oe)); // R9
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (st == ST_IDLE)); // R5
  AST_UPDATE_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> (st == ST_ACK && !rd)); // R4
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX || st == ST_MACK) |=> $stable(regs)); // R10
  AST_DRIVE_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == ST_ACK || st == ST_TX)); // R2

endmodule

// File: tb/cfg_i2c_slave_bench.sv
module cfg_i2c_slave_bench;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [47:0] regs_o;
  wire         sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [6];

  always #10 clk = ~clk;

  cfg_i2c_slave u_cfg_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o));

  function automatic logic [47:0] packed_model();
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[8*k +: 8] = model[k];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(2);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
    end
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
    ack = (sda_line == 1'b0);
    wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic rbyte(output logic [7:0] b, input bit give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(1); scl_m = 1'b1; wq(1); b[i] = sda_line; wq(1); scl_m = 1'b0;
    end
    wq(1);
    sda_m = ~give_ack; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    bit seen;
    model[0] = 8'h1E; model[1] = 8'hFF; model[2] = 8'hFF;
    model[3] = 8'h00; model[4] = 8'h00; model[5] = 8'h06;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq(2);
    chk(regs_o == 48'h06_00_00_FF_FF_1E, "R1 defaults", regs_o, 48'h06_00_00_FF_FF_1E);
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);

    bus_start(); wbyte(8'hA4, ack);
    chk(!ack, "R2 foreign write addr", ack, 0);
    wbyte(8'h00, ack); wbyte(8'h00, ack); wbyte(8'h11, ack); bus_stop();
    chk(regs_o == packed_model(), "R2 foreign transfer ignored", regs_o, packed_model());
    bus_start(); wbyte(8'hD7, ack);
    chk(!ack, "R2 foreign read addr", ack, 0);
    bus_stop();

    for (int n = 0; n <= 8; n++) begin
      bus_start(); wbyte(8'hD2, ack);
      chk(ack, "R2 write addr ack", ack, 1);
      wbyte(8'(n * 13 + 8'h40), ack);
      chk(ack, "R3 command ack", ack, 1);
      wbyte(8'(n + 3), ack);
      chk(ack, "R3 count ack", ack, 1);
      chk(regs_o == packed_model(), "R3 dummies discarded", regs_o, packed_model());
      for (int k = 0; k < n; k++) begin
        logic [7:0] v;
        v = 8'((n * 37 + k * 11 + 5) ^ (k << 5));
        wbyte(v, ack);
        if (k < 6) begin
          chk(ack, "R4 data ack", ack, 1);
          model[k] = v;
          chk(regs_o == packed_model(), "R4 visible at ack", regs_o, packed_model());
        end else begin
          chk(ack, "R6 extra byte ack", ack, 1);
          chk(regs_o == packed_model(), "R6 extra byte discarded", regs_o, packed_model());
        end
      end
      bus_stop();
      chk(regs_o == packed_model(), "R5 stop keeps state", regs_o, packed_model());

      bus_start(); wbyte(8'hD3, ack);
      chk(ack, "R2 read addr ack", ack, 1);
      rbyte(b, 1'b1);
      chk(b == 8'h06, "R7 count byte", b, 8'h06);
      for (int k = 0; k < 6; k++) begin
        rbyte(b, 1'b1);
        chk(b == model[k], "R7 register readback", b, model[k]);
      end
      rbyte(b, 1'b0);
      chk(b == 8'hFF, "R7 past last register", b, 8'hFF);
      bus_stop();
      chk(regs_o == packed_model(), "R10 read keeps registers", regs_o, packed_model());
    end

    bus_start(); wbyte(8'hD3, ack);
    rbyte(b, 1'b1);
    rbyte(b, 1'b0);
    chk(b == model[0], "R8 byte before nack", b, model[0]);
    seen = 1'b0;
    for (int i = 0; i < 18; i++) begin
      wq(1); scl_m = ~scl_m;
      if (sda_oe) seen = 1'b1;
    end
    scl_m = 1'b0; wq(1);
    chk(!seen, "R8 released after nack", seen, 0);
    bus_stop();

    bus_start(); wbyte(8'hD2, ack); wbyte(8'h00, ack); wbyte(8'h00, ack);
    wbyte(8'h5A, ack); bus_stop();
    model[0] = 8'h5A;
    chk(regs_o == packed_model(), "R9 write after nack restarts at 0", regs_o, packed_model());
    bus_start(); wbyte(8'hD2, ack); wbyte(8'h00, ack); wbyte(8'h00, ack);
    wbyte(8'hA5, ack); bus_stop();
    model[0] = 8'hA5;
    chk(regs_o == packed_model(), "R9 each transfer from reg 0", regs_o, packed_model());

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule